// File: doc/BRIEF.md
# Multiplexed 8-bit Bus Access Master

This block performs one single-byte read or write at a time on a narrow external bus where the same eight lines carry both the address and the data. A host raises a request together with a 16-bit address, a direction bit, a slot number and, for writes, a data byte. The block first presents the low address byte while pulsing a low-byte latch strobe. It then presents the high address byte while pulsing a high-byte latch strobe. After that it either releases the lines (read) or drives the write byte (write). It then selects one of two attached devices and pulls the read or write strobe low.

The attached device finishes the cycle by pulling an active-low acknowledge. That acknowledge is synchronised into the block's clock domain. On a read, the byte on the lines is captured when the synchronised acknowledge is seen low. If no acknowledge arrives within a configurable number of clock cycles, the block abandons the access and flags an error. Every control returns to its inactive level before the block reports completion with a one-cycle done pulse.

Top module: `mux_bus_master`

## Requirements
- R1: During and after reset, with no access running, both chip selects (`cs_n_o` = 2'b11), `rd_n_o` and `wr_n_o` are high, both latch strobes are low, and `busy_o` and `done_o` are low.
- R2: An accepted request first drives `addr_i[7:0]` on `bus_dout_o`, with `bus_doe_o` high and `stb_lo_o` high for HOLD_CYC cycles. The strobe is then low for one cycle while the byte stays on the lines, and only then does the high-byte phase begin.
- R3: The high-byte phase drives `addr_i[15:8]` with `stb_hi_o` high for HOLD_CYC cycles, then holds it for one further cycle with the strobe low. The two strobes are never high together, and neither is high while a chip select is low.
- R4: After the address phases, a read (`wr_i`=0) sets `bus_doe_o` low and keeps it low through the strobe phase. A write (`wr_i`=1) drives `wdata_i` with `bus_doe_o` high, and does so for one cycle with all controls inactive before the select.
- R5: Slot 0 pulls only `cs_n_o[0]` low (2'b10) and slot 1 pulls only `cs_n_o[1]` low (2'b01). At most one select is ever low, and each select stays low for the select cycle and the strobe phase.
- R6: One cycle after the select goes low, `rd_n_o` goes low for a read or `wr_n_o` goes low for a write. The two are never low together, and neither is low without a select.
- R7: `ack_n_i` passes through a two-flop synchroniser that resets to high. When the synchronised acknowledge is low during the strobe phase, a read captures `bus_din_i` into `rdata_o` in the same cycle. The next cycle has every control inactive, `done_o` high and `err_o` low. A write leaves `rdata_o` unchanged.
- R8: If the synchronised acknowledge is still high in the TMO_CYC-th cycle of the strobe phase, the access is aborted. The next cycle has every control inactive, `done_o` high and `err_o` high. An acknowledge seen in that last cycle still counts as success. `err_o` and `rdata_o` hold their values until the next completion.
- R9: `busy_o` is high from the cycle after a request is accepted up to and including the `done_o` cycle, and it is low in the cycle after it. `done_o` lasts exactly one cycle. A request raised while `busy_o` is high is ignored, and the access in progress keeps its address, slot and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, sampled when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| slot_i | input | 1 | Target device: 0 or 1 |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done |
| rdata_o | output | 8 | Byte captured by the last successful read |
| bus_dout_o | output | 8 | Value driven on the shared lines |
| bus_doe_o | output | 1 | Output enable for the shared lines |
| bus_din_i | input | 8 | Value read from the shared lines |
| cs_n_o | output | 2 | Device selects, active low, bit index = slot |
| stb_lo_o | output | 1 | Low address byte latch strobe, active high |
| stb_hi_o | output | 1 | High address byte latch strobe, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ack_n_i | input | 1 | Device acknowledge, active low, asynchronous |

## Verification
The bound checker enforces the bus invariants on every cycle. It checks that at most one select is low, that the read and write strobes are exclusive and never active without a select, and that the latch strobes are exclusive and never overlap a select. It also checks that the lines are released during a read strobe and driven during a write strobe, that everything is idle when not busy, and that done is a clean single pulse followed by idle. The order of the phases, the hold length of each latch strobe, the two-cycle acknowledge latency and the exact timeout boundary cannot be seen from one cycle alone. The bench's cycle model shows these, using acknowledge delays just inside and just outside the timeout window, a device that never answers, and a request raised in the middle of an access.

// File: rtl/mbm_pkg.sv
// Shared definitions for the multiplexed bus master.
// Assumes an 8-bit shared bus and a 16-bit address split into two bytes.
package mbm_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2 * DATA_W;
    localparam int NUM_SEL = 2;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ALO,
        PH_ALO_OFF,
        PH_AHI,
        PH_AHI_OFF,
        PH_DATA,
        PH_SEL,
        PH_STRB,
        PH_FIN
    } phase_t;
endpackage

// File: rtl/mbm_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2; the output resets to RST_VAL.
module mbm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shift_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= {STAGES{RST_VAL}};
        else        shift_q <= {shift_q[STAGES-2:0], d_i};
    end

    assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/mbm_counter.sv
// Cycle counter that flags the LIMIT-th enabled cycle.
// Assumes LIMIT >= 1; clear has priority over enable.
module mbm_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    localparam int            W   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0]  TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Count enabled cycles, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (en_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = en_i && (cnt_q == TOP);
endmodule

// File: rtl/mux_bus_master.sv
// Single-byte access master for a shared address/data bus with two devices.
// Sequence: low address latch, high address latch, data setup, select,
// strobe until the synchronised acknowledge is seen low or a timeout expires,
// then one idle completion cycle carrying done.
// Assumes the device holds read data stable while it asserts acknowledge.
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int HOLD_CYC    = 2,
    parameter int TMO_CYC     = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic              slot_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic [NUM_SEL-1:0] cs_n_o,
    output logic              stb_lo_o,
    output logic              stb_hi_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    input  logic              ack_n_i
);
    phase_t            st_q, st_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_q;
    logic              slot_q;
    logic              err_q;
    logic              ack_s;
    logic              hold_en, hold_last;
    logic              tmo_en, tmo_last;
    logic              sel_active;

    mbm_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_n_i),
        .q_o   (ack_s)
    );

    assign hold_en = (st_q == PH_ALO) || (st_q == PH_AHI);

    mbm_counter #(.LIMIT(HOLD_CYC)) u_hold_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (hold_last || !hold_en),
        .en_i   (hold_en),
        .last_o (hold_last)
    );

    assign tmo_en = (st_q == PH_STRB);

    mbm_counter #(.LIMIT(TMO_CYC)) u_tmo_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!tmo_en),
        .en_i   (tmo_en),
        .last_o (tmo_last)
    );

    // Choose the next phase of the access sequence.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PH_IDLE:    if (req_i) st_nx = PH_ALO;
            PH_ALO:     if (hold_last) st_nx = PH_ALO_OFF;
            PH_ALO_OFF: st_nx = PH_AHI;
            PH_AHI:     if (hold_last) st_nx = PH_AHI_OFF;
            PH_AHI_OFF: st_nx = PH_DATA;
            PH_DATA:    st_nx = PH_SEL;
            PH_SEL:     st_nx = PH_STRB;
            PH_STRB:    if (!ack_s || tmo_last) st_nx = PH_FIN;
            PH_FIN:     st_nx = PH_IDLE;
            default:    st_nx = PH_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_nx;
    end

    // Capture the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            slot_q  <= 1'b0;
        end else if (st_q == PH_IDLE && req_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            wr_q    <= wr_i;
            slot_q  <= slot_i;
        end
    end

    // Record the outcome of the strobe phase: read byte and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (st_q == PH_STRB) begin
            if (!ack_s) begin
                err_q <= 1'b0;
                if (!wr_q) rdata_q <= bus_din_i;
            end else if (tmo_last) begin
                err_q <= 1'b1;
            end
        end
    end

    assign sel_active = (st_q == PH_SEL) || (st_q == PH_STRB);

    // One select line per device, active only for the latched slot.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign cs_n_o[g] = !(sel_active && (slot_q == 1'(g)));
    end

    // Decode the line drivers and strobes from the current phase.
    always_comb begin
        stb_lo_o   = 1'b0;
        stb_hi_o   = 1'b0;
        rd_n_o     = 1'b1;
        wr_n_o     = 1'b1;
        bus_doe_o  = 1'b0;
        bus_dout_o = wdata_q;
        unique case (st_q)
            PH_ALO, PH_ALO_OFF: begin
                bus_doe_o  = 1'b1;
                bus_dout_o = addr_q[DATA_W-1:0];
                stb_lo_o   = (st_q == PH_ALO);
            end
            PH_AHI, PH_AHI_OFF: begin
                bus_doe_o  = 1'b1;
                bus_dout_o = addr_q[ADDR_W-1:DATA_W];
                stb_hi_o   = (st_q == PH_AHI);
            end
            PH_DATA, PH_SEL: bus_doe_o = wr_q;
            PH_STRB: begin
                bus_doe_o = wr_q;
                rd_n_o    = wr_q;
                wr_n_o    = !wr_q;
            end
            default: ;
        endcase
    end

    assign busy_o  = (st_q != PH_IDLE);
    assign done_o  = (st_q == PH_FIN);
    assign err_o   = err_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/mux_bus_master_chk.sv
// Property checker for the bus master, attached by bind.
// Assumes the port names of mux_bus_master.
module mux_bus_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] cs_n_o,
    input logic       stb_lo_o,
    input logic       stb_hi_o,
    input logic       rd_n_o,
    input logic       wr_n_o,
    input logic       bus_doe_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o == 2'b11 && rd_n_o && wr_n_o && !stb_lo_o && !stb_hi_o)); // R1
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_lo_o && stb_hi_o)); // R2
    AST_LATCH_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_lo_o || stb_hi_o) |-> (bus_doe_o && cs_n_o == 2'b11)); // R3
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !bus_doe_o); // R4
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> bus_doe_o); // R4
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_o) <= 1); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R6
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> (cs_n_o != 2'b11)); // R6
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o == 2'b11 && rd_n_o && wr_n_o && busy_o)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R9
endmodule

bind mux_bus_master mux_bus_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cs_n_o    (cs_n_o),
    .stb_lo_o  (stb_lo_o),
    .stb_hi_o  (stb_hi_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .bus_doe_o (bus_doe_o)
);

// File: tb/mux_bus_master_test.sv
`timescale 1ns/1ps
module mux_bus_master_test;
    localparam int HOLD = 2;
    localparam int TMO  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0, slot = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done, err;
    logic [7:0]  rdata, dout, din;
    logic        doe, stb_lo, stb_hi, rd_n, wr_n;
    logic [1:0]  cs_n;
    logic        ack_n;

    always #2 clk = ~clk;

    mux_bus_master #(.HOLD_CYC(HOLD), .TMO_CYC(TMO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .slot_i(slot),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
        .err_o(err), .rdata_o(rdata), .bus_dout_o(dout), .bus_doe_o(doe),
        .bus_din_i(din), .cs_n_o(cs_n), .stb_lo_o(stb_lo), .stb_hi_o(stb_hi),
        .rd_n_o(rd_n), .wr_n_o(wr_n), .ack_n_i(ack_n)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Device responder: latches address bytes, answers after ack_lat strobe cycles.
    int          ack_lat = 0;
    int          strb_cnt = 0;
    logic [7:0]  dev_lo = '0, dev_hi = '0, dev_w = '0;
    initial begin
        din   = 8'h00;
        ack_n = 1'b1;
        forever begin
            @(negedge clk);
            if (stb_lo && doe) dev_lo = dout;
            if (stb_hi && doe) dev_hi = dout;
            din = dev_lo ^ dev_hi ^ 8'h5A;
            if (!rd_n || !wr_n) begin
                if (!wr_n) dev_w = dout;
                if (ack_lat >= 0 && strb_cnt >= ack_lat) ack_n = 1'b0;
                strb_cnt++;
            end else begin
                ack_n    = 1'b1;
                strb_cnt = 0;
            end
        end
    end

    // Behavioural cycle model of the expected block.
    int          mph = 0, mcnt = 0;
    bit          mwr = 0, mslot = 0, merr = 0;
    logic [15:0] maddr = '0;
    logic [7:0]  mwd = '0, mrd = '0;
    bit          ackq[$] = '{1'b1, 1'b1};
    always @(posedge clk) begin
        bit s;
        if (!rst_n) begin
            mph = 0; mcnt = 0; merr = 0; mrd = '0;
            ackq = '{1'b1, 1'b1};
        end else begin
            s = ackq[0];
            void'(ackq.pop_front());
            ackq.push_back(ack_n);
            case (mph)
                0: if (req) begin
                       mph = 1; mcnt = 0;
                       mwr = wr; mslot = slot; maddr = addr; mwd = wdata;
                   end
                1, 3: if (mcnt == HOLD - 1) begin mph++; mcnt = 0; end
                      else mcnt++;
                2, 4, 5: mph++;
                6: begin mph = 7; mcnt = 0; end
                7: if (!s) begin
                       merr = 0;
                       if (!mwr) mrd = din;
                       mph = 8;
                   end else if (mcnt == TMO - 1) begin
                       merr = 1; mph = 8;
                   end else mcnt++;
                default: mph = 0;
            endcase
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [1:0] e_cs;
            logic       e_oe;
            logic [7:0] e_d;
            e_cs = (mph == 6 || mph == 7) ? (mslot ? 2'b01 : 2'b10) : 2'b11;
            e_oe = (mph >= 1 && mph <= 4) || ((mph >= 5 && mph <= 7) && mwr);
            e_d  = (mph == 1 || mph == 2) ? maddr[7:0] :
                   (mph == 3 || mph == 4) ? maddr[15:8] : mwd;
            chk("R5", "cs_n", 16'(cs_n), 16'(e_cs));
            chk("R2", "stb_lo", 16'(stb_lo), 16'(mph == 1));
            chk("R3", "stb_hi", 16'(stb_hi), 16'(mph == 3));
            chk("R6", "rd_n", 16'(rd_n), 16'(!(mph == 7 && !mwr)));
            chk("R6", "wr_n", 16'(wr_n), 16'(!(mph == 7 && mwr)));
            chk("R4", "doe", 16'(doe), 16'(e_oe));
            if (e_oe) chk("R4", "dout", 16'(dout), 16'(e_d));
            chk("R9", "busy", 16'(busy), 16'(mph != 0));
            chk("R9", "done", 16'(done), 16'(mph == 8));
            chk("R8", "err", 16'(err), 16'(merr));
            chk("R7", "rdata", 16'(rdata), 16'(mrd));
        end
    end

    task automatic txn(input bit w, input bit s, input logic [15:0] a,
                       input logic [7:0] d, input int lat, input bit exp_err,
                       input bit poke);
        int guard;
        @(negedge clk);
        ack_lat = lat;
        req = 1'b1; wr = w; slot = s; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0; slot = 1'b0; addr = '0; wdata = '0;
        chk("R9", "busy after accept", 16'(busy), 16'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req = 1'b1; wr = !w; slot = !s; addr = ~a; wdata = ~d;
            @(negedge clk);
            req = 1'b0; addr = '0;
        end
        guard = 0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9", "done reached", 16'(done), 16'd1);
        chk(exp_err ? "R8" : "R7", "err at done", 16'(err), 16'(exp_err));
        chk("R2", "latched low byte", 16'(dev_lo), 16'(a[7:0]));
        chk("R3", "latched high byte", 16'(dev_hi), 16'(a[15:8]));
        if (!w && !exp_err)
            chk("R7", "read data", 16'(rdata), 16'(a[7:0] ^ a[15:8] ^ 8'h5A));
        if (w) chk("R4", "written byte", 16'(dev_w), 16'(d));
        @(negedge clk);
        chk("R9", "idle after done", 16'(busy), 16'd0);
        chk("R1", "selects idle", 16'(cs_n), 16'h3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset cs_n", 16'(cs_n), 16'h3);
        chk("R1", "reset rd/wr", 16'({rd_n, wr_n}), 16'h3);
        chk("R1", "reset strobes", 16'({stb_lo, stb_hi}), 16'h0);
        chk("R1", "reset busy/done", 16'({busy, done}), 16'h0);
        rst_n = 1'b1;
        txn(1'b0, 1'b0, 16'h12A5, 8'h00, 0,  1'b0, 1'b0);
        txn(1'b1, 1'b1, 16'hBEEF, 8'h3C, 3,  1'b0, 1'b0);
        txn(1'b0, 1'b1, 16'h0F81, 8'h00, 17, 1'b0, 1'b0);
        txn(1'b1, 1'b0, 16'h7001, 8'hC3, 18, 1'b1, 1'b0);
        txn(1'b0, 1'b0, 16'h4455, 8'h00, -1, 1'b1, 1'b0);
        txn(1'b0, 1'b0, 16'h9A3E, 8'h00, 1,  1'b0, 1'b0);
        txn(1'b1, 1'b0, 16'h2468, 8'h99, 2,  1'b0, 1'b1);
        txn(1'b0, 1'b1, 16'hFF00, 8'h00, 5,  1'b0, 1'b1);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule